// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a processor reach the management registers of Ethernet PHYs through a small memory-mapped register set. Software packs one management request into a single 32-bit command word: a valid flag, a read or write opcode, the PHY address, the register address and, for writes, 16 bits of payload. An accepted command becomes one Clause 22 frame on the MDC/MDIO pins. While the frame runs, a busy flag in the status register stays set.

When a read completes, the 16 bits returned by the PHY go into the data register. An error flag goes into the same register if the PHY fails to pull the bus low in the second turnaround slot. The management clock comes from the system clock through a programmable half-period divider. The MDIO pin is driven through separate output and output-enable signals, so the pad's tri-state buffer sits outside the block.

Software polls busy until it reads clear, writes a command, polls busy again, and for a read then samples the data register.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status and data registers read 0, `mdio_oe` is 0 and `mdc_o` is low.
- R2: The register map is: status at address 0x0 (bit 3 = busy), command at 0x8 (write only) and data at 0xC. A read that is strobed with `bus_ren` returns its value on `bus_rdata` one clock later. Any other address reads as 0.
- R3: Command word layout: bit 31 = valid, bits 29:25 = PHY address, bits 24:20 = register address, bits 19:4 = write payload, bit 1 = write, bit 2 = read. A frame starts only when valid is 1 and exactly one of bits 1 and 2 is 1.
- R4: A command write that arrives while busy is set starts no frame and does not disturb the frame in progress.
- R5: Busy reads 1 from the cycle after an accepted command write. It returns to 0 only after all 64 frame bits have been transferred.
- R6: A write frame is 64 bits, sent MSB first: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16-bit payload. `mdio_oe` is 1 for the whole frame.
- R7: A read frame sends 32 ones, start 01, opcode 10, PHY address and register address. The master then releases MDIO (`mdio_oe` = 0) for the two turnaround bits and the 16 data bits.
- R8: At the end of a read, the 16 data bits sampled from `mdio_i`, MSB first, are placed in data register bits 15:0. The data register changes only at the end of a read.
- R9: If `mdio_i` is 1 when the second turnaround bit of a read is sampled, data register bit 16 is set for that read. The bit is 0 otherwise. Bit 17 and bits 31:18 read 0.
- R10: `mdc_o` has a high phase and a low phase of `MDC_HALF` system clocks each. `mdio_o` changes only when `mdc_o` falls. `mdio_i` is sampled when `mdc_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after `bus_ren` |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
The assertions check these properties on every cycle:
- busy rises only right after a write to the command address;
- `mdio_o` moves only on a falling MDC edge;
- the pin is driven only while busy;
- the data register changes only as busy falls.

Only the bench scenarios can show the rest, because it depends on values across a whole frame:
- the exact bit patterns of the frames;
- the release of the pin during read turnaround;
- the MSB-first assembly of read data;
- the turnaround error flag;
- the rejection of malformed commands and of commands sent while busy.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  localparam int REG_STATUS = 0;
  localparam int REG_CMD    = 8;
  localparam int REG_DATA   = 12;

  localparam int BUSY_BIT   = 3;
  localparam int VALID_BIT  = 31;
  localparam int PHY_LSB    = 25;
  localparam int REGAD_LSB  = 20;
  localparam int WDATA_LSB  = 4;
  localparam int OPWR_BIT   = 1;
  localparam int OPRD_BIT   = 2;
  localparam int ERR_BIT    = 16;

  localparam int PREAMBLE_LEN = 32;
  localparam int FRAME_LEN    = 64;
  localparam int TA_IDX       = 46;
  localparam int DATA_IDX     = 48;
  localparam int IDX_W        = $clog2(FRAME_LEN);

  typedef struct packed {
    logic        is_rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap      = (cnt == LAST);
  assign rise_tick = wrap & ~mdc;
  assign fall_tick = wrap & mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rd_value,
  output logic        rd_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(TA_IDX - 1);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_IDX + 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_IDX);

  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     bit_idx;
  logic                 pend, run, is_rd;
  logic [FRAME_LEN-1:0] load_word;

  always_comb begin
    load_word = {{PREAMBLE_LEN{1'b1}}, 2'b01,
                 cmd.is_rd ? 2'b10 : 2'b01,
                 cmd.phy, cmd.regad,
                 cmd.is_rd ? 2'b11 : 2'b10,
                 cmd.is_rd ? 16'hFFFF : cmd.wdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      bit_idx  <= '0;
      pend     <= 1'b0;
      run      <= 1'b0;
      is_rd    <= 1'b0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
      done     <= 1'b0;
      rd_value <= '0;
      rd_err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !pend && !run) begin
        pend     <= 1'b1;
        shreg    <= load_word;
        is_rd    <= cmd.is_rd;
        rd_value <= '0;
        rd_err   <= 1'b0;
      end
      if (fall_tick) begin
        if (pend) begin
          pend    <= 1'b0;
          run     <= 1'b1;
          bit_idx <= '0;
          mdio_o  <= shreg[FRAME_LEN-1];
          mdio_oe <= 1'b1;
          shreg   <= shreg << 1;
        end else if (run) begin
          if (bit_idx == LAST_IDX) begin
            run     <= 1'b0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            done    <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            mdio_o  <= shreg[FRAME_LEN-1];
            shreg   <= shreg << 1;
            if (is_rd && bit_idx == REL_IDX) mdio_oe <= 1'b0;
          end
        end
      end
      if (rise_tick && run && is_rd) begin
        if (bit_idx == TA2_IDX && mdio_i) rd_err <= 1'b1;
        if (bit_idx >= DAT_IDX) rd_value <= {rd_value[14:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_reg_if.sv
`timescale 1ns/1ps
module mdio_reg_if
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              done,
  input  logic [15:0]       rd_value,
  input  logic              rd_err,
  output logic              start,
  output mdio_cmd_t         cmd,
  output logic              busy,
  output logic [31:0]       data_reg
);
  logic accept, op_ok, unused_bits;

  assign op_ok       = bus_wdata[OPWR_BIT] ^ bus_wdata[OPRD_BIT];
  assign accept      = bus_wen && (bus_addr == ADDR_W'(REG_CMD)) && !busy &&
                       bus_wdata[VALID_BIT] && op_ok;
  assign unused_bits = ^{bus_wdata[30], bus_wdata[3], bus_wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      start    <= 1'b0;
      busy     <= 1'b0;
      cmd      <= '0;
      data_reg <= '0;
    end else begin
      start <= accept;
      if (accept) begin
        busy      <= 1'b1;
        cmd.is_rd <= bus_wdata[OPRD_BIT];
        cmd.phy   <= bus_wdata[PHY_LSB +: 5];
        cmd.regad <= bus_wdata[REGAD_LSB +: 5];
        cmd.wdata <= bus_wdata[WDATA_LSB +: 16];
      end else if (done) begin
        busy <= 1'b0;
        if (cmd.is_rd) data_reg <= {15'b0, rd_err, rd_value};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_ren) begin
      if (bus_addr == ADDR_W'(REG_STATUS))
        bus_rdata <= 32'(busy) << BUSY_BIT;
      else if (bus_addr == ADDR_W'(REG_DATA))
        bus_rdata <= data_reg;
      else
        bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 2,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic        rise_tick, fall_tick, start, done, rd_err, busy_w;
  logic [15:0] rd_value;
  logic [31:0] data_reg_w;
  mdio_cmd_t   cmd;

  mdio_mdc_gen #(.HALF(MDC_HALF)) clkgen_i (
    .clk(clk), .rst(rst), .mdc(mdc_o),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_reg_if #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_ren(bus_ren), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .rd_value(rd_value), .rd_err(rd_err),
    .start(start), .cmd(cmd), .busy(busy_w), .data_reg(data_reg_w)
  );

  mdio_frame_engine engine_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
    .rd_value(rd_value), .rd_err(rd_err)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_master_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wen,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              busy,
  input logic [31:0]       data_reg,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(bus_wen) && $past(bus_addr) == ADDR_W'(8))); // R5

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> (!mdc && $past(mdc))); // R10

  AST_DRIVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy); // R7

  AST_DATA_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_reg) |-> $fell(busy)); // R8
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
  .busy(busy_w), .data_reg(data_reg_w), .mdc(mdc_o),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wen = 1'b0, bus_ren = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc_o, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_bad = 0;
  logic [15:0] phy_val = '0;
  logic        ta_bad = 1'b0;
  logic [63:0] cap = '0, oecap = '0;
  int          rcnt = 64;
  int          frames = 0;
  logic [31:0] exp_data = '0;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.MDC_HALF(HALF), .ADDR_W(4)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_ren(bus_ren), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: sample on MDC rise, drive on MDC fall
  always @(posedge mdc_o) begin
    if (rcnt >= 64 && mdio_oe) begin
      rcnt = 0;
      frames = frames + 1;
    end
    if (rcnt < 64) begin
      cap[63-rcnt]   = mdio_oe ? mdio_o : 1'b0;
      oecap[63-rcnt] = mdio_oe;
      rcnt = rcnt + 1;
    end
  end

  always @(negedge mdc_o) begin
    if (rcnt == 47) mdio_i = ta_bad;
    else if (rcnt >= 48 && rcnt < 64) mdio_i = phy_val[15-(rcnt-48)];
    else mdio_i = 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk); bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_ren = 1'b1;
    @(negedge clk); bus_ren = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_read(4'h0, s);
      if (!s[3]) break;
    end
  endtask

  function automatic logic [31:0] mk_cmd(logic v, logic rd, logic wr,
                                         logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
    return {v, 1'b0, phy, ra, d, 1'b0, rd, wr, 1'b0};
  endfunction

  // {is_rd, phy, reg, data, ta_bad}
  localparam logic [27:0] VEC [7] = '{
    {1'b0, 5'd1,  5'd0,  16'h1234, 1'b0},
    {1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b0},
    {1'b0, 5'd0,  5'd0,  16'h0000, 1'b0},
    {1'b1, 5'd5,  5'd2,  16'hA5C3, 1'b0},
    {1'b1, 5'd31, 5'd17, 16'h0001, 1'b0},
    {1'b1, 5'd10, 5'd3,  16'h8000, 1'b1},
    {1'b1, 5'd0,  5'd0,  16'h0000, 1'b0}
  };

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    realtime t0, t1;
    int f0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 mdio_oe", 64'(mdio_oe), 64'd0);
    bus_read(4'h0, r); check("R1 status", 64'(r), 64'd0);
    bus_read(4'hC, r); check("R1 data", 64'(r), 64'd0);

    // R10 MDC phase length
    @(posedge mdc_o); t0 = $realtime;
    @(negedge mdc_o); t1 = $realtime;
    check("R10 high phase", 64'(int'((t1 - t0) / 4.0)), 64'(HALF));
    @(posedge mdc_o); t0 = $realtime;
    check("R10 low phase", 64'(int'((t0 - t1) / 4.0)), 64'(HALF));

    // Table-driven frames: R3 R5 R6 R7 R8 R9
    foreach (VEC[k]) begin
      automatic logic        rd  = VEC[k][27];
      automatic logic [4:0]  phy = VEC[k][26:22];
      automatic logic [4:0]  ra  = VEC[k][21:17];
      automatic logic [15:0] dv  = VEC[k][16:1];
      automatic logic        tb  = VEC[k][0];
      phy_val = dv; ta_bad = tb; f0 = frames;
      bus_write(4'h8, mk_cmd(1'b1, rd, !rd, phy, ra, dv));
      bus_read(4'h0, r); check("R5 busy set", 64'(r[3]), 64'd1);
      wait_idle();
      check("R5 all bits moved", 64'(rcnt), 64'd64);
      check("R3 one frame", 64'(frames), 64'(f0 + 1));
      if (!rd) begin
        check("R6 write frame", cap,
              {32'hFFFFFFFF, 2'b01, 2'b01, phy, ra, 2'b10, dv});
        check("R6 drive", oecap, {64{1'b1}});
      end else begin
        check("R7 read header", 64'(cap[63:18]),
              64'({32'hFFFFFFFF, 2'b01, 2'b10, phy, ra}));
        check("R7 release", oecap, {{46{1'b1}}, 18'b0});
        exp_data = {15'b0, tb, dv};
      end
      bus_read(4'hC, r);
      check(tb ? "R9 ta error" : "R8 data reg", 64'(r), 64'(exp_data));
    end

    // R2 command address reads 0, unmapped address reads 0
    bus_read(4'h8, r); check("R2 cmd reads zero", 64'(r), 64'd0);
    bus_read(4'h4, r); check("R2 unmapped", 64'(r), 64'd0);

    // R3 malformed commands start nothing
    f0 = frames;
    bus_write(4'h8, mk_cmd(1'b0, 1'b1, 1'b0, 5'd2, 5'd2, 16'h0));
    bus_read(4'h0, r); check("R3 no valid", 64'(r), 64'd0);
    bus_write(4'h8, mk_cmd(1'b1, 1'b1, 1'b1, 5'd2, 5'd2, 16'h0));
    bus_read(4'h0, r); check("R3 both ops", 64'(r), 64'd0);
    bus_write(4'h8, mk_cmd(1'b1, 1'b0, 1'b0, 5'd2, 5'd2, 16'h0));
    bus_read(4'h0, r); check("R3 no op", 64'(r), 64'd0);
    repeat (100) @(negedge clk);
    check("R3 no frame", 64'(frames), 64'(f0));
    bus_read(4'hC, r); check("R3 data kept", 64'(r), 64'(exp_data));

    // R4 command while busy ignored
    phy_val = 16'h1357; ta_bad = 1'b0; f0 = frames;
    bus_write(4'h8, mk_cmd(1'b1, 1'b1, 1'b0, 5'd3, 5'd4, 16'h0));
    repeat (20) @(negedge clk);
    bus_write(4'h8, mk_cmd(1'b1, 1'b0, 1'b1, 5'd9, 5'd9, 16'hBEEF));
    wait_idle();
    check("R4 header intact", 64'(cap[63:18]),
          64'({32'hFFFFFFFF, 2'b01, 2'b10, 5'd3, 5'd4}));
    bus_read(4'hC, r); check("R4 read result", 64'(r), 64'h1357);
    repeat (400) @(negedge clk);
    check("R4 no second frame", 64'(frames), 64'(f0 + 1));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule